// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Selector

This block decides, for every processor in a multi-CPU interrupt controller, whether that processor's ordinary interrupt line should be driven. Each processor has three pieces of state: a bitmap of sources that are currently requesting it, a bitmap of sources it is currently servicing, and a current task priority. Each source's priority arrives as a packed vector from the source configuration logic. An upstream routing stage issues one update strobe per source event. The strobe names the target CPU, the source, the delivery class, and the new and previous activity of that source.

For an ordinary-class update, the block records the request in the requesting bitmap. It then scans both bitmaps for their strongest entries and applies the priority rules to raise, hide or withdraw the ordinary output. Critical and machine-check class updates skip all of this. They only move a per-CPU reference count for their class, and that class's output follows whether the count is non-zero. The strongest pending request of each CPU is reported so that acknowledge logic can use it. The in-service bitmap is loaded through a plain set/clear port. Task-priority writes re-evaluate the pending requests against the new value. Every output decision is registered and appears in the cycle after the strobe.

Top module: `cpu_prio_select`

## Requirements
- R1: After reset, all interrupt outputs are low, every pending-valid flag is low, each pending index reads all ones, and each CPU's task priority is the maximum value (15 for 4-bit priorities).
- R2: An ordinary-class update (class code 0) with the active flag set records the source as pending even when it cannot be signalled, and one with the active flag clear removes it. `pend_vld`/`pend_idx` report the strongest pending source of each CPU.
- R3: An ordinary-class active update whose source priority is less than or equal to the CPU's task priority leaves the ordinary output unasserted. Every output change appears one clock after the strobe or write that causes it.
- R4: The strongest-entry scan replaces the current best only on a strictly greater priority, so among equal priorities the lowest source index wins.
- R5: An ordinary-class active update that passes the task priority is hidden, leaving the output as it was, when any source is in service with a priority greater than or equal to its own. Otherwise the ordinary output is asserted.
- R6: An ordinary-class inactive update, or an active update blocked by the task priority, keeps the output as it was when the strongest remaining pending priority exceeds both the task priority and the strongest in-service priority. Otherwise it lowers the output.
- R7: Class code 1 (critical) and class code 2 (machine check) updates only count. A transition from inactive to active increments that class's per-CPU counter, and a transition from active to inactive decrements it, never below zero. The class output is high exactly while the count is non-zero. These updates ignore all priorities, and class code 3 has no effect.
- R8: A task-priority write sets the CPU's ordinary output to whether its strongest pending priority exceeds both the new task priority and the strongest in-service priority.
- R9: An in-service set/clear only changes the in-service bitmap. The ordinary output does not change until the next update or task-priority write for that CPU.
- R10: When an update and a task-priority write reach the same CPU in one cycle, the update decides the output using the old task priority, and the new task priority is still stored.
- R11: Updates, writes and in-service operations for one CPU leave every other CPU's state and outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_prio | input | NUM_SRC*PRIO_W | Priority of every source, source s at bits [s*PRIO_W +: PRIO_W] |
| upd_valid | input | 1 | Update strobe |
| upd_cpu | input | $clog2(NUM_CPU) | Target CPU of the update |
| upd_src | input | $clog2(NUM_SRC) | Source of the update |
| upd_class | input | 2 | Delivery class: 0 ordinary, 1 critical, 2 machine check, 3 none |
| upd_active | input | 1 | New activity of the source |
| upd_was_active | input | 1 | Previous activity of the source |
| tp_wr | input | 1 | Task-priority write strobe |
| tp_cpu | input | $clog2(NUM_CPU) | CPU whose task priority is written |
| tp_value | input | PRIO_W | New task priority |
| svc_valid | input | 1 | In-service bitmap operation strobe |
| svc_set | input | 1 | 1 sets, 0 clears the in-service bit |
| svc_cpu | input | $clog2(NUM_CPU) | CPU of the in-service operation |
| svc_src | input | $clog2(NUM_SRC) | Source of the in-service operation |
| irq_int | output | NUM_CPU | Ordinary interrupt output per CPU |
| irq_crit | output | NUM_CPU | Critical interrupt output per CPU |
| irq_mchk | output | NUM_CPU | Machine-check output per CPU |
| pend_vld | output | NUM_CPU | CPU has at least one pending ordinary request |
| pend_idx | output | NUM_CPU*$clog2(NUM_SRC) | Strongest pending source per CPU, all ones when none |

## Verification
The bench builds the block with two CPUs, eight sources and 4-bit priorities. With two CPUs, every scenario can run on one CPU while the other is watched for leakage. With eight sources, the all-ones empty index is a small visible value, 7. With 4-bit priorities, the reset task priority of 15 blocks every ordinary request, so requests that are recorded but not signalled show up straight after reset. The directed scenarios cover equal-priority ties between sources, requests hidden by an equal in-service priority, and counters driven into repeated and surplus releases. They also cover an update and a task-priority write landing in the same cycle.

// File: rtl/cpu_prio_select_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the per-CPU priority selector.
// Assumes the class code is two bits wide and values are fixed by the
// routing stage that feeds the block.
package cpu_prio_select_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_CRIT   = 2'd1,
        CLS_MCHK   = 2'd2,
        CLS_NONE   = 2'd3
    } irq_class_e;

    // Number of counted (non-ordinary) classes per CPU.
    localparam int unsigned NUM_COUNTED = 2;

endpackage

// File: rtl/psel_scan.sv
`timescale 1ns/1ps
// Strongest-entry scan over a source bitmap.
// Walks sources from index 0 upward and takes a new best only on a strictly
// greater priority, so ties settle on the lowest index. An empty bitmap
// gives found=0, idx all ones, best zero. Purely combinational.
module psel_scan #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]    bits,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   best
);

    // Ascending argmax with strict comparison.
    always_comb begin
        found = 1'b0;
        idx   = '1;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i] && (!found || prio[i*PW +: PW] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/psel_refcnt.sv
`timescale 1ns/1ps
// Reference counter for one counted output class of one CPU.
// Assumes the caller reports each source's previous activity faithfully;
// surplus releases are dropped at zero and surplus claims saturate.
module psel_refcnt #(
    parameter int unsigned CW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic active,
    input  logic was_active,
    output logic live
);

    logic [CW-1:0] cnt_q;
    logic          inc;
    logic          dec;

    // Claim on inactive-to-active, release on active-to-inactive.
    always_comb begin
        inc = hit && active && !was_active && (cnt_q != '1);
        dec = hit && !active && was_active && (cnt_q != '0);
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Output follows a non-zero count.
    always_comb live = (cnt_q != '0);

endmodule

// File: rtl/psel_lane.sv
`timescale 1ns/1ps
// Delivery state and decision logic for one CPU.
// Holds the pending and in-service bitmaps, the task priority, the
// registered ordinary output and the counted-class counters.
// Assumes all strobes arriving here are already decoded for this CPU.
module psel_lane #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = 5,
    parameter int unsigned CW = 6,
    parameter int unsigned NC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*PW-1:0] src_prio,
    input  logic            upd_hit,
    input  logic [NC-1:0]   cnt_hit,
    input  logic [IW-1:0]   upd_src,
    input  logic            upd_active,
    input  logic            upd_was_active,
    input  logic            tp_hit,
    input  logic [PW-1:0]   tp_value,
    input  logic            svc_hit,
    input  logic            svc_set,
    input  logic [IW-1:0]   svc_src,
    output logic            irq_int,
    output logic [NC-1:0]   irq_cnt,
    output logic            pend_vld,
    output logic [IW-1:0]   pend_idx
);

    logic [N-1:0]  raised_q;
    logic [N-1:0]  raised_nxt;
    logic [N-1:0]  svc_q;
    logic [PW-1:0] tp_q;
    logic          int_q;
    logic          int_d;
    logic [PW-1:0] req_prio;

    logic          rn_found;
    logic [IW-1:0] rn_idx_unused;
    logic [PW-1:0] rn_best;
    logic          sv_found;
    logic [IW-1:0] sv_idx_unused;
    logic [PW-1:0] sv_best;
    logic [PW-1:0] pq_best_unused;

    // Pending bitmap as it will be after this cycle's update.
    always_comb begin
        raised_nxt = raised_q;
        if (upd_hit) begin
            raised_nxt[upd_src] = upd_active;
        end
    end

    // Priority of the source named by the update.
    always_comb req_prio = src_prio[int'(upd_src)*PW +: PW];

    // Strongest pending entry after the update, used for decisions.
    psel_scan #(.N(N), .PW(PW), .IW(IW)) i_scan_next (
        .bits  (raised_nxt),
        .prio  (src_prio),
        .found (rn_found),
        .idx   (rn_idx_unused),
        .best  (rn_best)
    );

    // Strongest in-service entry.
    psel_scan #(.N(N), .PW(PW), .IW(IW)) i_scan_svc (
        .bits  (svc_q),
        .prio  (src_prio),
        .found (sv_found),
        .idx   (sv_idx_unused),
        .best  (sv_best)
    );

    // Strongest registered pending entry, reported outward.
    psel_scan #(.N(N), .PW(PW), .IW(IW)) i_scan_pend (
        .bits  (raised_q),
        .prio  (src_prio),
        .found (pend_vld),
        .idx   (pend_idx),
        .best  (pq_best_unused)
    );

    // Ordinary-output decision: update first, then task-priority re-check.
    always_comb begin
        int_d = int_q;
        if (upd_hit) begin
            if (upd_active && (req_prio > tp_q)) begin
                if (!(sv_found && (req_prio <= sv_best))) begin
                    int_d = 1'b1;
                end
            end else if (!(rn_found && (rn_best > tp_q) &&
                           (!sv_found || (rn_best > sv_best)))) begin
                int_d = 1'b0;
            end
        end else if (tp_hit) begin
            int_d = rn_found && (rn_best > tp_value) &&
                    (!sv_found || (rn_best > sv_best));
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
            svc_q    <= '0;
            tp_q     <= '1;
            int_q    <= 1'b0;
        end else begin
            raised_q <= raised_nxt;
            int_q    <= int_d;
            if (svc_hit) begin
                svc_q[svc_src] <= svc_set;
            end
            if (tp_hit) begin
                tp_q <= tp_value;
            end
        end
    end

    always_comb irq_int = int_q;

    // One reference counter per counted class.
    for (genvar k = 0; k < NC; k++) begin : g_cnt
        psel_refcnt #(.CW(CW)) i_refcnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (cnt_hit[k]),
            .active     (upd_active),
            .was_active (upd_was_active),
            .live       (irq_cnt[k])
        );
    end

endmodule

// File: rtl/cpu_prio_select.sv
`timescale 1ns/1ps
// Top of the per-CPU priority selector.
// Decodes the update, task-priority and in-service strobes per CPU and
// instantiates one lane per CPU. Assumes NUM_CPU >= 2 and NUM_SRC >= 2.
module cpu_prio_select #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU),
    localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      upd_valid,
    input  logic [CPU_W-1:0]          upd_cpu,
    input  logic [SRC_W-1:0]          upd_src,
    input  logic [1:0]                upd_class,
    input  logic                      upd_active,
    input  logic                      upd_was_active,
    input  logic                      tp_wr,
    input  logic [CPU_W-1:0]          tp_cpu,
    input  logic [PRIO_W-1:0]         tp_value,
    input  logic                      svc_valid,
    input  logic                      svc_set,
    input  logic [CPU_W-1:0]          svc_cpu,
    input  logic [SRC_W-1:0]          svc_src,
    output logic [NUM_CPU-1:0]        irq_int,
    output logic [NUM_CPU-1:0]        irq_crit,
    output logic [NUM_CPU-1:0]        irq_mchk,
    output logic [NUM_CPU-1:0]        pend_vld,
    output logic [NUM_CPU*SRC_W-1:0]  pend_idx
);
    import cpu_prio_select_pkg::*;

    localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);

    irq_class_e cls;

    // Class code as an enumerated value.
    always_comb cls = irq_class_e'(upd_class);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic                   here;
        logic                   norm_hit;
        logic [NUM_COUNTED-1:0] cnt_hit;
        logic                   tp_hit;
        logic                   svc_hit;
        logic [NUM_COUNTED-1:0] cnt_out;

        // Per-CPU strobe decode.
        always_comb begin
            here       = upd_valid && (upd_cpu == CPU_W'(c));
            norm_hit   = here && (cls == CLS_NORMAL);
            cnt_hit[0] = here && (cls == CLS_CRIT);
            cnt_hit[1] = here && (cls == CLS_MCHK);
            tp_hit     = tp_wr && (tp_cpu == CPU_W'(c));
            svc_hit    = svc_valid && (svc_cpu == CPU_W'(c));
        end

        psel_lane #(
            .N  (NUM_SRC),
            .PW (PRIO_W),
            .IW (SRC_W),
            .CW (CNT_W),
            .NC (NUM_COUNTED)
        ) i_lane (
            .clk            (clk),
            .rst_n          (rst_n),
            .src_prio       (src_prio),
            .upd_hit        (norm_hit),
            .cnt_hit        (cnt_hit),
            .upd_src        (upd_src),
            .upd_active     (upd_active),
            .upd_was_active (upd_was_active),
            .tp_hit         (tp_hit),
            .tp_value       (tp_value),
            .svc_hit        (svc_hit),
            .svc_set        (svc_set),
            .svc_src        (svc_src),
            .irq_int        (irq_int[c]),
            .irq_cnt        (cnt_out),
            .pend_vld       (pend_vld[c]),
            .pend_idx       (pend_idx[c*SRC_W +: SRC_W])
        );

        // Counted-class outputs onto the top-level vectors.
        always_comb begin
            irq_crit[c] = cnt_out[0];
            irq_mchk[c] = cnt_out[1];
        end
    end

endmodule

// File: rtl/cpu_prio_select_chk.sv
`timescale 1ns/1ps
// Property checker for the per-CPU priority selector, bound to the top.
// Relates output transitions to the strobes of the previous cycle.
module cpu_prio_select_chk #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic [CPU_W-1:0]   upd_cpu,
    input logic [1:0]         upd_class,
    input logic               upd_active,
    input logic               upd_was_active,
    input logic               tp_wr,
    input logic [CPU_W-1:0]   tp_cpu,
    input logic               svc_valid,
    input logic [NUM_CPU-1:0] irq_int,
    input logic [NUM_CPU-1:0] irq_crit,
    input logic [NUM_CPU-1:0] irq_mchk,
    input logic [NUM_CPU-1:0] pend_vld
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_int == '0 && irq_crit == '0 && irq_mchk == '0 && pend_vld == '0)); // R1

    AST_SVC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(svc_valid && !upd_valid && !tp_wr) |-> $stable(irq_int)); // R9

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        AST_INT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_int[c]) |-> $past((upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd0 && upd_active) ||
                                        (tp_wr && tp_cpu == CPU_W'(c)))); // R3

        AST_INT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_int[c]) |-> $past((upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd0) ||
                                        (tp_wr && tp_cpu == CPU_W'(c)))); // R6

        AST_CRIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_crit[c]) |-> $past(upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd1 &&
                                         upd_active && !upd_was_active)); // R7

        AST_CRIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_crit[c]) |-> $past(upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd1 &&
                                         !upd_active && upd_was_active)); // R7

        AST_MCHK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_mchk[c]) |-> $past(upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd2 &&
                                         upd_active && !upd_was_active)); // R7

        AST_MCHK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_mchk[c]) |-> $past(upd_valid && upd_cpu == CPU_W'(c) && upd_class == 2'd2 &&
                                         !upd_active && upd_was_active)); // R7
    end

endmodule

bind cpu_prio_select cpu_prio_select_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd_valid      (upd_valid),
    .upd_cpu        (upd_cpu),
    .upd_class      (upd_class),
    .upd_active     (upd_active),
    .upd_was_active (upd_was_active),
    .tp_wr          (tp_wr),
    .tp_cpu         (tp_cpu),
    .svc_valid      (svc_valid),
    .irq_int        (irq_int),
    .irq_crit       (irq_crit),
    .irq_mchk       (irq_mchk),
    .pend_vld       (pend_vld)
);

// File: tb/test_cpu_prio_select.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_cpu_prio_select;

    localparam int NUM_CPU = 2;
    localparam int NUM_SRC = 8;
    localparam int PRIO_W  = 4;
    localparam int CPU_W   = $clog2(NUM_CPU);
    localparam int SRC_W   = $clog2(NUM_SRC);

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic [NUM_SRC*PRIO_W-1:0] src_prio;
    logic                      upd_valid;
    logic [CPU_W-1:0]          upd_cpu;
    logic [SRC_W-1:0]          upd_src;
    logic [1:0]                upd_class;
    logic                      upd_active;
    logic                      upd_was_active;
    logic                      tp_wr;
    logic [CPU_W-1:0]          tp_cpu;
    logic [PRIO_W-1:0]         tp_value;
    logic                      svc_valid;
    logic                      svc_set;
    logic [CPU_W-1:0]          svc_cpu;
    logic [SRC_W-1:0]          svc_src;
    logic [NUM_CPU-1:0]        irq_int;
    logic [NUM_CPU-1:0]        irq_crit;
    logic [NUM_CPU-1:0]        irq_mchk;
    logic [NUM_CPU-1:0]        pend_vld;
    logic [NUM_CPU*SRC_W-1:0]  pend_idx;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    cpu_prio_select #(
        .NUM_CPU (NUM_CPU),
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) i_cpu_prio_select (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_prio       (src_prio),
        .upd_valid      (upd_valid),
        .upd_cpu        (upd_cpu),
        .upd_src        (upd_src),
        .upd_class      (upd_class),
        .upd_active     (upd_active),
        .upd_was_active (upd_was_active),
        .tp_wr          (tp_wr),
        .tp_cpu         (tp_cpu),
        .tp_value       (tp_value),
        .svc_valid      (svc_valid),
        .svc_set        (svc_set),
        .svc_cpu        (svc_cpu),
        .svc_src        (svc_src),
        .irq_int        (irq_int),
        .irq_crit       (irq_crit),
        .irq_mchk       (irq_mchk),
        .pend_vld       (pend_vld),
        .pend_idx       (pend_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] idx_of(input int cpu);
        return 32'(pend_idx[cpu*SRC_W +: SRC_W]);
    endfunction

    task automatic set_prio(input int src, input int p);
        src_prio[src*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_prio = '0;
        upd_valid = 1'b0; upd_cpu = '0; upd_src = '0; upd_class = '0;
        upd_active = 1'b0; upd_was_active = 1'b0;
        tp_wr = 1'b0; tp_cpu = '0; tp_value = '0;
        svc_valid = 1'b0; svc_set = 1'b0; svc_cpu = '0; svc_src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One update strobe; results are visible at the returning negedge.
    task automatic upd(input int cpu, input int src, input int cls, input bit act, input bit was);
        @(negedge clk);
        upd_valid = 1'b1; upd_cpu = CPU_W'(cpu); upd_src = SRC_W'(src);
        upd_class = 2'(cls); upd_active = act; upd_was_active = was;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic wr_tp(input int cpu, input int val);
        @(negedge clk);
        tp_wr = 1'b1; tp_cpu = CPU_W'(cpu); tp_value = PRIO_W'(val);
        @(negedge clk);
        tp_wr = 1'b0;
    endtask

    task automatic svc_op(input int cpu, input int src, input bit set);
        @(negedge clk);
        svc_valid = 1'b1; svc_set = set; svc_cpu = CPU_W'(cpu); svc_src = SRC_W'(src);
        @(negedge clk);
        svc_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 int", 32'(irq_int), 0);
        chk("R1 crit", 32'(irq_crit), 0);
        chk("R1 mchk", 32'(irq_mchk), 0);
        chk("R1 pend_vld", 32'(pend_vld), 0);
        chk("R1 idx cpu0", idx_of(0), 7);
        chk("R1 idx cpu1", idx_of(1), 7);
        set_prio(0, 15);
        upd(0, 0, 0, 1'b1, 1'b0);
        chk("R1 tp15 blocks prio15", 32'(irq_int[0]), 0);
        chk("R2 recorded vld", 32'(pend_vld[0]), 1);
        chk("R2 recorded idx", idx_of(0), 0);
    endtask

    task automatic t_block_record();
        do_reset();
        set_prio(3, 9);
        upd(0, 3, 0, 1'b1, 1'b0);
        chk("R3 blocked", 32'(irq_int[0]), 0);
        chk("R2 pend idx", idx_of(0), 3);
        wr_tp(0, 9);
        chk("R3 equal tp blocks", 32'(irq_int[0]), 0);
        wr_tp(0, 8);
        chk("R8 tp lowered raises", 32'(irq_int[0]), 1);
        wr_tp(0, 12);
        chk("R8 tp raised lowers", 32'(irq_int[0]), 0);
        upd(0, 3, 0, 1'b0, 1'b1);
        chk("R2 cleared", 32'(pend_vld[0]), 0);
        chk("R2 cleared idx", idx_of(0), 7);
    endtask

    task automatic t_tie();
        do_reset();
        set_prio(5, 7); set_prio(2, 7); set_prio(6, 3);
        wr_tp(1, 0);
        upd(1, 5, 0, 1'b1, 1'b0);
        chk("R5 asserted", 32'(irq_int[1]), 1);
        chk("R2 idx 5", idx_of(1), 5);
        chk("R11 other int", 32'(irq_int[0]), 0);
        chk("R11 other pend", 32'(pend_vld[0]), 0);
        upd(1, 2, 0, 1'b1, 1'b0);
        chk("R4 tie lowest", idx_of(1), 2);
        upd(1, 6, 0, 1'b1, 1'b0);
        chk("R4 weaker ignored", idx_of(1), 2);
        upd(1, 2, 0, 1'b0, 1'b1);
        chk("R4 next tie", idx_of(1), 5);
        chk("R6 stays high", 32'(irq_int[1]), 1);
        upd(1, 5, 0, 1'b0, 1'b1);
        chk("R6 remaining idx", idx_of(1), 6);
        chk("R6 remaining keeps", 32'(irq_int[1]), 1);
        upd(1, 6, 0, 1'b0, 1'b1);
        chk("R6 empty lowers", 32'(irq_int[1]), 0);
        chk("R2 empty", 32'(pend_vld[1]), 0);
    endtask

    task automatic t_hidden();
        do_reset();
        set_prio(1, 10); set_prio(4, 10); set_prio(0, 11);
        wr_tp(0, 0);
        chk("R8 nothing pending", 32'(irq_int[0]), 0);
        svc_op(0, 1, 1'b1);
        chk("R9 set quiet", 32'(irq_int[0]), 0);
        upd(0, 4, 0, 1'b1, 1'b0);
        chk("R5 hidden equal", 32'(irq_int[0]), 0);
        chk("R2 hidden recorded", idx_of(0), 4);
        upd(0, 0, 0, 1'b1, 1'b0);
        chk("R5 above service", 32'(irq_int[0]), 1);
        svc_op(0, 0, 1'b1);
        chk("R9 set keeps high", 32'(irq_int[0]), 1);
        svc_op(0, 0, 1'b0);
        upd(0, 0, 0, 1'b0, 1'b1);
        chk("R6 lowered by service", 32'(irq_int[0]), 0);
        svc_op(0, 1, 1'b0);
        chk("R9 clear quiet", 32'(irq_int[0]), 0);
        chk("R11 other cpu", 32'(irq_int[1]), 0);
        wr_tp(0, 0);
        chk("R8 reevaluate", 32'(irq_int[0]), 1);
    endtask

    task automatic t_counted();
        do_reset();
        upd(1, 2, 1, 1'b1, 1'b0);
        chk("R7 crit up", 32'(irq_crit[1]), 1);
        chk("R7 bypass int", 32'(irq_int[1]), 0);
        chk("R7 not recorded", 32'(pend_vld[1]), 0);
        upd(1, 3, 1, 1'b1, 1'b0);
        upd(1, 3, 1, 1'b1, 1'b1);
        upd(1, 2, 1, 1'b0, 1'b1);
        chk("R7 one left", 32'(irq_crit[1]), 1);
        upd(1, 3, 1, 1'b0, 1'b1);
        chk("R7 crit down", 32'(irq_crit[1]), 0);
        upd(1, 3, 1, 1'b0, 1'b1);
        chk("R7 no underflow", 32'(irq_crit[1]), 0);
        upd(1, 4, 1, 1'b1, 1'b0);
        upd(1, 4, 1, 1'b0, 1'b1);
        chk("R7 count at zero", 32'(irq_crit[1]), 0);
        upd(0, 0, 2, 1'b1, 1'b0);
        chk("R7 mchk up", 32'(irq_mchk[0]), 1);
        chk("R7 class split", 32'(irq_crit), 0);
        upd(0, 0, 2, 1'b0, 1'b1);
        chk("R7 mchk down", 32'(irq_mchk[0]), 0);
        upd(0, 1, 3, 1'b1, 1'b0);
        chk("R7 class3 outputs", 32'({irq_int, irq_crit, irq_mchk}), 0);
        chk("R7 class3 pend", 32'(pend_vld), 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        set_prio(1, 9); set_prio(2, 5);
        @(negedge clk);
        upd_valid = 1'b1; upd_cpu = '0; upd_src = SRC_W'(1); upd_class = 2'd0;
        upd_active = 1'b1; upd_was_active = 1'b0;
        tp_wr = 1'b1; tp_cpu = '0; tp_value = PRIO_W'(3);
        @(negedge clk);
        upd_valid = 1'b0; tp_wr = 1'b0;
        chk("R10 old tp used", 32'(irq_int[0]), 0);
        upd(0, 2, 0, 1'b1, 1'b0);
        chk("R10 new tp stored", 32'(irq_int[0]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        src_prio = '0;
        upd_valid = 1'b0; upd_cpu = '0; upd_src = '0; upd_class = '0;
        upd_active = 1'b0; upd_was_active = 1'b0;
        tp_wr = 1'b0; tp_cpu = '0; tp_value = '0;
        svc_valid = 1'b0; svc_set = 1'b0; svc_cpu = '0; svc_src = '0;
        t_reset();
        t_block_record();
        t_tie();
        t_hidden();
        t_counted();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule